// File: doc/BRIEF.md
# Power Management Control and Status Register

This block holds the 16-bit power-management control and status word of a network function. System software reads it and writes it through a simple register port with two byte-lane enables. The block tracks a wake status flag and a wake enable flag, and drives an active-low wake request pin from them. It holds a data selector with a derived read-only scale field, and the current device power state.

Writes are gated by a power-management strap. Power-state writes that name an unsupported state are dropped. The wake flags sit in a reset domain chosen by the auxiliary-power strap. When auxiliary power is present they survive a bus reset. When it is absent, the release of the bus reset clears them. The power-good reset (`rst_ni`) clears everything.

Top module: `pm_csr`

## Requirements
- R1: After `rst_ni` the word reads with bits 15, 12:0 all zero, `pme_no` is 1 and `pwr_state_o` is 00 (D0); with `mng_en_i` low the whole word reads 0x0000.
- R2: A cycle with `wake_evt_i` high sets bit 15 (wake status) at that clock edge, whatever the value of bit 8 (wake enable).
- R3: A write with the upper lane enabled and data bit 15 at 1 clears bit 15; data bit 15 at 0 leaves it unchanged; if `wake_evt_i` is high in the same cycle, bit 15 stays 1.
- R4: Bit 8 (wake enable) takes data bit 8 on an upper-lane write only while `pm_en_i` is 1; with `pm_en_i` at 0 such a write leaves it unchanged.
- R5: `pme_no` is 0 exactly when bits 15 and 8 are both 1, and 1 otherwise.
- R6: Bits 14:13 read 01 when `mng_en_i` is 1 and bits 12:9 hold 0, 3, 4 or 7; they read 00 in every other case.
- R7: Bits 12:9 (data selector) take data bits 12:9 on an upper-lane write only while `pm_en_i` is 1.
- R8: Bits 7:2 always read 000000, whatever is written.
- R9: Bits 1:0 (`pwr_state_o`: 00 D0, 01 D1, 10 D2, 11 D3) take data bits 1:0 on a lower-lane write only when the value is 00 or 11 and `pm_en_i` is 1; any other such write leaves the state unchanged.
- R10: `wr_be_i[0]` enables writes to bits 7:0 and `wr_be_i[1]` enables writes to bits 15:8; fields in a disabled lane are unchanged.
- R11: At the first clock edge after `bus_rst_ni` rises, the power state becomes D0. Bits 15 and 8 clear at that edge only if `aux_pwr_i` is 0. With `aux_pwr_i` at 1 they keep their values. While `bus_rst_ni` stays low, no field changes on account of it.
- R12: Bit 8 is cleared by `rst_ni` and set again only by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-good reset, active low, asynchronous |
| bus_rst_ni | input | 1 | Bus reset, active low; acted on at its release |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 2 | Byte-lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Current register word |
| wake_evt_i | input | 1 | Wakeup condition detected, one cycle per event |
| pm_en_i | input | 1 | Power management enabled strap |
| mng_en_i | input | 1 | Manageability enabled strap |
| aux_pwr_i | input | 1 | Auxiliary power present strap |
| pme_no | output | 1 | Wake request, active low |
| pwr_state_o | output | 2 | Current power state |

## Verification
Two functions of the block can land in the same clock cycle. The wake status flag can see a software clear and a new wake event at once. The release of the bus reset can coincide with a power-state write. The bench drives a one-to-clear write of bit 15 with `wake_evt_i` high on the same edge, and expects bit 15 to read 1 with `pme_no` still low. It also writes D3 while the bus reset is held and after it is released, and compares the state with D0 as R11 gives it.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned PS_W    = 2;
  localparam int unsigned SCL_W   = 2;
  localparam int unsigned RSV_W   = 6;
  localparam int unsigned ST_BIT  = 15;
  localparam int unsigned EN_BIT  = 8;
  localparam int unsigned SEL_LSB = 9;
  localparam int unsigned SCL_LSB = 13;
  localparam int unsigned PS_LSB  = 0;

  typedef enum logic [PS_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwr_state_e;

  function automatic logic [SCL_W-1:0] scale_of(input logic [SEL_W-1:0] sel, input logic mng);
    logic hit;
    hit = (sel == 4'd0) || (sel == 4'd3) || (sel == 4'd4) || (sel == 4'd7);
    return (mng && hit) ? 2'b01 : 2'b00;
  endfunction
endpackage

// File: rtl/pm_rst_edge.sv
module pm_rst_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_ni,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= bus_rst_ni;
  end

  assign rise_o = bus_rst_ni & ~prev_q;
endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hi_i,
  input  logic wd_st_i,
  input  logic wd_en_i,
  input  logic pm_en_i,
  input  logic aux_pwr_i,
  input  logic bus_rise_i,
  input  logic wake_evt_i,
  output logic st_o,
  output logic en_o
);
  logic st_q, en_q, clr;

  // without aux power the bus reset release reaches the wake flags
  assign clr = bus_rise_i & ~aux_pwr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= 1'b0;
      en_q <= 1'b0;
    end else if (clr) begin
      st_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      // a new event outranks a same-cycle clear
      st_q <= wake_evt_i | (st_q & ~(wr_hi_i & wd_st_i));
      if (wr_hi_i && pm_en_i) en_q <= wd_en_i;
    end
  end

  assign st_o = st_q;
  assign en_o = en_q;
endmodule

// File: rtl/pm_state_ctl.sv
module pm_state_ctl
  import pm_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [PS_W-1:0]  wd_ps_i,
  input  logic [SEL_W-1:0] wd_sel_i,
  input  logic             pm_en_i,
  input  logic             bus_rise_i,
  output logic [PS_W-1:0]  ps_o,
  output logic [SEL_W-1:0] sel_o
);
  pwr_state_e      ps_q;
  logic [SEL_W-1:0] sel_q;
  logic            ps_ok;

  assign ps_ok = (wd_ps_i == PS_D0) || (wd_ps_i == PS_D3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= PS_D0;
      sel_q <= '0;
    end else begin
      if (bus_rise_i)                      ps_q <= PS_D0;
      else if (wr_lo_i && pm_en_i && ps_ok) ps_q <= pwr_state_e'(wd_ps_i);
      if (wr_hi_i && pm_en_i) sel_q <= wd_sel_i;
    end
  end

  assign ps_o  = ps_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/pm_csr.sv
module pm_csr
  import pm_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_be_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wake_evt_i,
  input  logic              pm_en_i,
  input  logic              mng_en_i,
  input  logic              aux_pwr_i,
  output logic              pme_no,
  output logic [PS_W-1:0]   pwr_state_o
);
  logic             wr_lo, wr_hi, bus_rise, st, en;
  logic [PS_W-1:0]  ps;
  logic [SEL_W-1:0] sel;

  assign wr_lo = wr_en_i & wr_be_i[0];
  assign wr_hi = wr_en_i & wr_be_i[1];

  pm_rst_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .rise_o(bus_rise)
  );

  pm_wake_ctl u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_hi_i(wr_hi),
    .wd_st_i(wr_data_i[ST_BIT]), .wd_en_i(wr_data_i[EN_BIT]),
    .pm_en_i(pm_en_i), .aux_pwr_i(aux_pwr_i), .bus_rise_i(bus_rise),
    .wake_evt_i(wake_evt_i), .st_o(st), .en_o(en)
  );

  pm_state_ctl u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wd_ps_i(wr_data_i[PS_LSB +: PS_W]), .wd_sel_i(wr_data_i[SEL_LSB +: SEL_W]),
    .pm_en_i(pm_en_i), .bus_rise_i(bus_rise), .ps_o(ps), .sel_o(sel)
  );

  assign rd_data_o   = {st, scale_of(sel, mng_en_i), sel, en, {RSV_W{1'b0}}, ps};
  assign pme_no      = ~(st & en);
  assign pwr_state_o = ps;
endmodule

// File: rtl/pm_csr_chk.sv
module pm_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_be_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        wake_evt_i,
  input logic        pm_en_i,
  input logic        mng_en_i,
  input logic        aux_pwr_i,
  input logic        pme_no,
  input logic [1:0]  pwr_state_o
);
  logic prev_bus, rise_c, sel_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_bus <= 1'b1;
    else         prev_bus <= bus_rst_ni;
  end
  assign rise_c  = bus_rst_ni & ~prev_bus;
  assign sel_hit = rd_data_o[12:9] inside {4'd0, 4'd3, 4'd4, 4'd7};

  p_wake_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_evt_i && !(rise_c && !aux_pwr_i)) |=> rd_data_o[15]);

  p_en_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_en_i |=> !$rose(rd_data_o[8]));

  p_pme_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_no == !(rd_data_o[15] && rd_data_o[8]));

  p_scale_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[14:13] == ((mng_en_i && sel_hit) ? 2'b01 : 2'b00));

  p_rsv_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:2] == 6'd0);

  p_ps_filter_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i[0] && !rise_c && (wr_data_i[1] != wr_data_i[0])) |=> $stable(pwr_state_o));

  p_ps_d0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_c |=> pwr_state_o == 2'b00);

  p_aux_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_c && aux_pwr_i && !wr_en_i && !wake_evt_i) |=> $stable(rd_data_o[15]) && $stable(rd_data_o[8]));
endmodule

bind pm_csr pm_csr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .wr_en_i(wr_en_i),
  .wr_be_i(wr_be_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
  .wake_evt_i(wake_evt_i), .pm_en_i(pm_en_i), .mng_en_i(mng_en_i),
  .aux_pwr_i(aux_pwr_i), .pme_no(pme_no), .pwr_state_o(pwr_state_o)
);

// File: tb/pm_csr_tb.sv
module pm_csr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_be_i = 2'b00;
  logic [15:0] wr_data_i = 16'h0;
  logic [15:0] rd_data_o;
  logic        wake_evt_i = 1'b0;
  logic        pm_en_i = 1'b1;
  logic        mng_en_i = 1'b0;
  logic        aux_pwr_i = 1'b0;
  logic        pme_no;
  logic [1:0]  pwr_state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pm_csr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .wr_en_i(wr_en_i),
    .wr_be_i(wr_be_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .wake_evt_i(wake_evt_i), .pm_en_i(pm_en_i), .mng_en_i(mng_en_i),
    .aux_pwr_i(aux_pwr_i), .pme_no(pme_no), .pwr_state_o(pwr_state_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one write cycle; result visible at the following negedge
  task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic wake = 1'b0);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_be_i = be; wr_data_i = d; wake_evt_i = wake;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = 2'b00; wr_data_i = 16'h0; wake_evt_i = 1'b0;
  endtask

  task automatic wake_pulse();
    @(negedge clk_i); wake_evt_i = 1'b1;
    @(negedge clk_i); wake_evt_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    mng_en_i = 1'b0;
    do_reset();
    chk("R1 word", rd_data_o, 16'h0000);
    chk("R1 pme_no", {15'd0, pme_no}, 16'd1);
    chk("R1 state", {14'd0, pwr_state_o}, 16'd0);
  endtask

  task automatic t_state();
    pm_en_i = 1'b1;
    wr(2'b01, 16'hFFFF);
    chk("R8 reserved zero", rd_data_o, 16'h0003);
    wr(2'b01, 16'h0001);
    chk("R9 D1 dropped", {14'd0, pwr_state_o}, 16'd3);
    wr(2'b01, 16'h0002);
    chk("R9 D2 dropped", {14'd0, pwr_state_o}, 16'd3);
    wr(2'b01, 16'h0000);
    chk("R9 D0 taken", {14'd0, pwr_state_o}, 16'd0);
    pm_en_i = 1'b0;
    wr(2'b01, 16'h0003);
    chk("R9 gated by pm_en", {14'd0, pwr_state_o}, 16'd0);
    pm_en_i = 1'b1;
  endtask

  task automatic t_lanes();
    wr(2'b01, 16'h1E03);
    chk("R10 upper lane off", rd_data_o, 16'h0003);
    wr(2'b10, 16'h1E00);
    chk("R10 lower lane off", rd_data_o, 16'h1E03);
    pm_en_i = 1'b0;
    wr(2'b10, 16'h0000);
    chk("R7 sel gated", rd_data_o, 16'h1E03);
    pm_en_i = 1'b1;
    wr(2'b11, 16'h0000);
    chk("R7 sel written", rd_data_o, 16'h0000);
  endtask

  task automatic t_scale();
    mng_en_i = 1'b1;
    for (int s = 0; s < 16; s++) begin
      logic [1:0] e;
      e = (s == 0 || s == 3 || s == 4 || s == 7) ? 2'b01 : 2'b00;
      wr(2'b10, 16'(s) << 9);
      chk("R6 scale", {14'd0, rd_data_o[14:13]}, {14'd0, e});
    end
    wr(2'b10, 16'h0000);
    mng_en_i = 1'b0;
    @(negedge clk_i);
    chk("R6 scale no mng", {14'd0, rd_data_o[14:13]}, 16'd0);
  endtask

  task automatic t_wake();
    wake_pulse();
    chk("R2 status w/o enable", rd_data_o, 16'h8000);
    chk("R5 pme high", {15'd0, pme_no}, 16'd1);
    wr(2'b10, 16'h0100);
    chk("R4 enable set", rd_data_o, 16'h8100);
    chk("R5 pme low", {15'd0, pme_no}, 16'd0);
    wr(2'b01, 16'h8000);
    chk("R10 clear needs upper lane", rd_data_o, 16'h8100);
    wr(2'b10, 16'h8100, 1'b1);
    chk("R3 clear vs wake", rd_data_o, 16'h8100);
    chk("R3 pme kept", {15'd0, pme_no}, 16'd0);
    wr(2'b10, 16'h0100);
    chk("R3 write0 keeps", rd_data_o, 16'h8100);
    wr(2'b10, 16'h8100);
    chk("R3 w1c", rd_data_o, 16'h0100);
    chk("R5 pme released", {15'd0, pme_no}, 16'd1);
    pm_en_i = 1'b0;
    wr(2'b10, 16'h0000);
    chk("R4 clear gated", rd_data_o, 16'h0100);
    pm_en_i = 1'b1;
    wr(2'b10, 16'h0000);
    pm_en_i = 1'b0;
    wr(2'b10, 16'h0100);
    chk("R4 set gated", rd_data_o, 16'h0000);
    pm_en_i = 1'b1;
  endtask

  task automatic bus_reset_cycle();
    @(negedge clk_i); bus_rst_ni = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_be_i = 2'b01; wr_data_i = 16'h0003;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = 2'b00; wr_data_i = 16'h0;
    bus_rst_ni = 1'b1;
    wr_en_i = 1'b1; wr_be_i = 2'b01; wr_data_i = 16'h0003;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = 2'b00; wr_data_i = 16'h0;
  endtask

  task automatic t_bus_reset();
    wr(2'b11, 16'h0103);
    wake_pulse();
    aux_pwr_i = 1'b1;
    @(negedge clk_i); bus_rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R11 held low no change", rd_data_o, 16'h8103);
    bus_rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 aux keeps wake, D0", rd_data_o, 16'h8100);
    wr(2'b01, 16'h0003);
    bus_reset_cycle();
    chk("R11 release beats D3 write", {14'd0, pwr_state_o}, 16'd0);
    aux_pwr_i = 1'b0;
    @(negedge clk_i); bus_rst_ni = 1'b0;
    @(negedge clk_i); bus_rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 no aux clears wake", rd_data_o, 16'h0000);
    wr(2'b10, 16'h0100);
    do_reset();
    chk("R12 enable cleared by power-good", rd_data_o, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_state();
    t_lanes();
    t_scale();
    t_wake();
    t_bus_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule